// File: doc/BRIEF.md
# Two-Wire Bus Controller Mode and Control Register

This block is the CPU-side control register of a two-wire (I2C) bus controller. It holds four live bits: an interface enable, an interrupt enable, a master/slave select and a transmit/receive select. These bits gate the clock and data pin output enables, mask the interrupt line, and tell the bus engine which of the four operating modes it is in. Bit shifting, start/stop generation and bus clocking live in the engine, not here.

The engine reports three things to this block: a lost arbitration, the end of the first byte after a start condition together with its read/write bit, and a pending event. The mode bits are rewritten in hardware from these reports. A lost arbitration drops a master back to slave receive. An addressed slave turns to transmit or receive according to the read/write bit. The register bus has four byte addresses. One of them is shared: the enable bit decides whether that address reaches the own-address register or the mode register.

Top module: `i2cm_ctl_top`

## Requirements
- R1: After reset the control register reads 8'h0F: enable, interrupt enable, master and transmit all 0, so the mode is slave receive. The event flag is 0, both output enables are low and irq is low.
- R2: The control register is at address 0. Bit 7 is enable, bit 6 is interrupt enable, bit 5 is master and bit 4 is transmit. While enable is 0, scl_oe and sda_oe are 0 whatever the engine requests. While enable is 1, each output enable follows its engine request.
- R3: While enable is 0, reads and writes at address 1 reach the own-address register. Its bits 7:1 are the address and bit 0 is the format bit, where 0 means the addressing format. While enable is 1, address 1 reaches the mode register. A write at address 1 leaves the unselected register unchanged.
- R4: irq is high exactly when the interrupt-enable bit and the event flag are both 1.
- R5: Bits 5:4 encode the mode as follows: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. The is_master and is_tx outputs show bits 5 and 4.
- R6: A lost-arbitration strobe while bit 5 is 1 clears bits 5 and 4 on the same clock edge. While bit 5 is 0 the strobe has no effect.
- R7: A first-byte strobe in slave receive mode with the format bit at 0 loads bit 4 from the read/write input, where 1 means slave transmit. With the format bit at 1, or in any other mode, the strobe has no effect.
- R8: When a hardware update from R6 or R7 and a CPU write to address 0 fall on the same edge, bits 5:4 take the hardware value and bits 7:6 take the written value.
- R9: While the wait-priority input is high, sda_oe is 0. scl_oe is not affected.
- R10: The event flag is at bit 0 of address 2. It is set by the engine's event strobe and cleared by a CPU write of 0 to that bit. A write of 1 leaves it unchanged. A set and a clear on the same edge leave it set.
- R11: Reads return the live register contents, including bits changed by hardware. Unimplemented bits read 1: bits 3:0 at address 0, bits 7:1 at address 2, and all of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| arb_lost | input | 1 | Engine strobe: arbitration lost |
| addr_byte_done | input | 1 | Engine strobe: first byte after start received |
| addr_rw | input | 1 | Read/write bit of that byte |
| evt_set | input | 1 | Engine strobe: interrupt event |
| scl_drive_req | input | 1 | Engine request to pull clock low |
| sda_drive_req | input | 1 | Engine request to pull data low |
| wait_pri | input | 1 | Data pin given to the wait function |
| scl_oe | output | 1 | Clock pin output enable |
| sda_oe | output | 1 | Data pin output enable |
| irq | output | 1 | Interrupt request to CPU |
| is_master | output | 1 | Mode bit 5 |
| is_tx | output | 1 | Mode bit 4 |
| own_addr | output | 7 | Own slave address |
| addr_fmt | output | 1 | Format bit (0 = addressing format) |
| mode_q | output | 8 | Mode register contents |

## Verification
Two things can change bits 5:4 on the same clock edge: a CPU write to the control register and a hardware rewrite, either from a lost arbitration or from a read/write capture. A second pair of same-edge events is an engine event strobe and a CPU clear of the flag. The bench provokes both pairs on purpose with directed steps. It also produces them by chance in a long random run that biases the strobes and writes so that they often overlap. A behavioural model, which gives priority to the hardware update and to the set, judges every cycle by comparing its own register image with the bus read data and the mode outputs.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTL    = 2'd0;
  localparam logic [ADDR_W-1:0] A_SHARED = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd2;

  localparam int unsigned CTL_LSB  = 4;
  localparam int unsigned CTL_BITS = DATA_W - CTL_LSB;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } bus_mode_e;

  typedef struct packed {
    logic en;
    logic ien;
    logic mst;
    logic trs;
  } ctl_bits_t;

  localparam int unsigned PIN_SCL = 0;
  localparam int unsigned PIN_SDA = 1;
  localparam int unsigned NUM_PINS = 2;

endpackage

// File: rtl/i2cm_ctl_bits.sv
module i2cm_ctl_bits
  import i2cm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctl,
  input  ctl_bits_t wr_bits,
  input  logic      arb_lost,
  input  logic      byte_done,
  input  logic      rw_bit,
  input  logic      fmt_bit,
  output ctl_bits_t ctl_q
);

  ctl_bits_t ctl_d;
  logic      hw_arb;
  logic      hw_cap;
  logic      load;
  bus_mode_e cur_mode;

  assign cur_mode = bus_mode_e'({ctl_q.mst, ctl_q.trs});

  always_comb begin
    hw_arb = arb_lost && ctl_q.mst;
    hw_cap = byte_done && (cur_mode == MODE_SLV_RX) && !fmt_bit;
    load   = wr_ctl || hw_arb || hw_cap;
    ctl_d  = ctl_q;
    if (wr_ctl) begin
      ctl_d = wr_bits;
    end
    if (hw_arb) begin
      {ctl_d.mst, ctl_d.trs} = MODE_SLV_RX;
    end else if (hw_cap) begin
      ctl_d.mst = 1'b0;
      ctl_d.trs = rw_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (load) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/i2cm_shared_regs.sv
module i2cm_shared_regs #(
  parameter int unsigned DW       = 8,
  parameter logic [7:0]  SAR_RST  = 8'h00,
  parameter logic [7:0]  MODE_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_shared,
  input  logic          sel_mode,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sar_q,
  output logic [DW-1:0] mode_q
);

  localparam int unsigned NREG = 2;
  localparam int unsigned IDX_SAR = 0;
  localparam int unsigned IDX_MODE = 1;

  logic [DW-1:0] reg_q [NREG];
  logic [DW-1:0] reg_d [NREG];
  logic [NREG-1:0] reg_ld;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RST_V = (i == IDX_MODE) ? MODE_RST[DW-1:0] : SAR_RST[DW-1:0];

    always_comb begin
      reg_ld[i] = wr_shared && (sel_mode == (i == IDX_MODE));
      reg_d[i]  = reg_ld[i] ? wdata : reg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[i] <= RST_V;
      end else if (reg_ld[i]) begin
        reg_q[i] <= reg_d[i];
      end
    end
  end

  assign sar_q  = reg_q[IDX_SAR];
  assign mode_q = reg_q[IDX_MODE];

endmodule

// File: rtl/i2cm_evt_flag.sv
module i2cm_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  input  logic clr_bit,
  output logic pend_q
);

  logic pend_d;
  logic load;

  always_comb begin
    load   = set_evt || (clr_wr && !clr_bit);
    pend_d = set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (load) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/i2cm_pin_gate.sv
module i2cm_pin_gate #(
  parameter int unsigned    NP        = 2,
  parameter logic [NP-1:0]  WAIT_MASK = 2'b10
) (
  input  logic          en,
  input  logic          wait_pri,
  input  logic [NP-1:0] drive_req,
  output logic [NP-1:0] oe
);

  for (genvar p = 0; p < NP; p++) begin : g_pin
    if (WAIT_MASK[p]) begin : g_shared
      assign oe[p] = en && drive_req[p] && !wait_pri;
    end else begin : g_plain
      assign oe[p] = en && drive_req[p];
    end
  end

endmodule

// File: rtl/i2cm_ctl_top.sv
module i2cm_ctl_top
  import i2cm_pkg::*;
#(
  parameter logic [7:0] SAR_RST  = 8'h00,
  parameter logic [7:0] MODE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              arb_lost,
  input  logic              addr_byte_done,
  input  logic              addr_rw,
  input  logic              evt_set,
  input  logic              scl_drive_req,
  input  logic              sda_drive_req,
  input  logic              wait_pri,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq,
  output logic              is_master,
  output logic              is_tx,
  output logic [6:0]        own_addr,
  output logic              addr_fmt,
  output logic [DATA_W-1:0] mode_q
);

  localparam logic [NUM_PINS-1:0] WAIT_MASK = NUM_PINS'(1) << PIN_SDA;
  localparam logic [CTL_LSB-1:0]  CTL_PAD   = '1;
  localparam logic [DATA_W-2:0]   STAT_PAD  = '1;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  ctl_bits_t         ctl_q;
  logic [DATA_W-1:0] sar_q;
  logic              pend_q;
  logic              wr_ctl;
  logic              wr_shared;
  logic              wr_stat;
  logic [NUM_PINS-1:0] drv_req;
  logic [NUM_PINS-1:0] pin_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    wr_ctl    = bus_wr && (bus_addr == A_CTL);
    wr_shared = bus_wr && (bus_addr == A_SHARED);
    wr_stat   = bus_wr && (bus_addr == A_STAT);
  end

  i2cm_ctl_bits u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_ctl    (wr_ctl),
    .wr_bits   (ctl_bits_t'(bus_wdata[DATA_W-1:CTL_LSB])),
    .arb_lost  (arb_lost),
    .byte_done (addr_byte_done),
    .rw_bit    (addr_rw),
    .fmt_bit   (sar_q[0]),
    .ctl_q     (ctl_q)
  );

  i2cm_shared_regs #(
    .DW       (DATA_W),
    .SAR_RST  (SAR_RST),
    .MODE_RST (MODE_RST)
  ) u_shared (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_shared (wr_shared),
    .sel_mode  (ctl_q.en),
    .wdata     (bus_wdata),
    .sar_q     (sar_q),
    .mode_q    (mode_q)
  );

  i2cm_evt_flag u_evt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (evt_set),
    .clr_wr  (wr_stat),
    .clr_bit (bus_wdata[0]),
    .pend_q  (pend_q)
  );

  always_comb begin
    drv_req          = '0;
    drv_req[PIN_SCL] = scl_drive_req;
    drv_req[PIN_SDA] = sda_drive_req;
  end

  i2cm_pin_gate #(
    .NP        (NUM_PINS),
    .WAIT_MASK (WAIT_MASK)
  ) u_pins (
    .en        (ctl_q.en),
    .wait_pri  (wait_pri),
    .drive_req (drv_req),
    .oe        (pin_oe)
  );

  assign scl_oe    = pin_oe[PIN_SCL];
  assign sda_oe    = pin_oe[PIN_SDA];
  assign irq       = ctl_q.ien && pend_q;
  assign is_master = ctl_q.mst;
  assign is_tx     = ctl_q.trs;
  assign own_addr  = sar_q[DATA_W-1:1];
  assign addr_fmt  = sar_q[0];

  always_comb begin
    case (bus_addr)
      A_CTL:    bus_rdata = {ctl_q, CTL_PAD};
      A_SHARED: bus_rdata = ctl_q.en ? mode_q : sar_q;
      A_STAT:   bus_rdata = {STAT_PAD, pend_q};
      default:  bus_rdata = '1;
    endcase
  end

endmodule

// File: rtl/i2cm_ctl_chk.sv
module i2cm_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic arb_lost,
  input logic addr_byte_done,
  input logic addr_rw,
  input logic addr_fmt,
  input logic evt_set,
  input logic wait_pri,
  input logic en_bit,
  input logic ien_bit,
  input logic is_master,
  input logic is_tx,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic pend
);

  // R6
  arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && is_master) |=> (!is_master && !is_tx));

  // R7
  rw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_byte_done && !is_master && !is_tx && !addr_fmt) |=> (!is_master && (is_tx == $past(addr_rw))));

  // R2
  pins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_bit |-> (!scl_oe && !sda_oe));

  // R9
  wait_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_pri |-> !sda_oe);

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_bit && pend));

  // R10
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set |=> pend);

endmodule

bind i2cm_ctl_top i2cm_ctl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .arb_lost       (arb_lost),
  .addr_byte_done (addr_byte_done),
  .addr_rw        (addr_rw),
  .addr_fmt       (addr_fmt),
  .evt_set        (evt_set),
  .wait_pri       (wait_pri),
  .en_bit         (ctl_q.en),
  .ien_bit        (ctl_q.ien),
  .is_master      (is_master),
  .is_tx          (is_tx),
  .scl_oe         (scl_oe),
  .sda_oe         (sda_oe),
  .irq            (irq),
  .pend           (pend_q)
);

// File: tb/sim_i2cm_ctl_top.sv
`timescale 1ns/1ps
module sim_i2cm_ctl_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       arb_lost, addr_byte_done, addr_rw, evt_set;
  logic       scl_drive_req, sda_drive_req, wait_pri;
  logic       scl_oe, sda_oe, irq, is_master, is_tx, addr_fmt;
  logic [6:0] own_addr;
  logic [7:0] mode_q;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural image: {en,ien,mst,trs}
  bit [3:0] m_ctl;
  bit [7:0] m_sar, m_mode;
  bit       m_pend;

  i2cm_ctl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arb_lost(arb_lost),
    .addr_byte_done(addr_byte_done), .addr_rw(addr_rw), .evt_set(evt_set),
    .scl_drive_req(scl_drive_req), .sda_drive_req(sda_drive_req),
    .wait_pri(wait_pri), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .is_master(is_master), .is_tx(is_tx), .own_addr(own_addr),
    .addr_fmt(addr_fmt), .mode_q(mode_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [7:0] rd;
    bit en, ien, mst, trs;
    {en, ien, mst, trs} = m_ctl;
    case (bus_addr)
      2'd0:    rd = {m_ctl, 4'hF};
      2'd1:    rd = en ? m_mode : m_sar;
      2'd2:    rd = {7'h7F, m_pend};
      default: rd = 8'hFF;
    endcase
    cmp("rdata", bus_rdata, rd);
    cmp("irq", {7'd0, irq}, {7'd0, ien & m_pend});
    cmp("scl_oe", {7'd0, scl_oe}, {7'd0, en & scl_drive_req});
    cmp("sda_oe", {7'd0, sda_oe}, {7'd0, en & sda_drive_req & ~wait_pri});
    cmp("mode", {6'd0, is_master, is_tx}, {6'd0, mst, trs});
    cmp("own_addr", {1'b0, own_addr}, {1'b0, m_sar[7:1]});
    cmp("fmt", {7'd0, addr_fmt}, {7'd0, m_sar[0]});
    cmp("mode_q", mode_q, m_mode);
  endtask

  task automatic model_update();
    bit [3:0] nc;
    nc = m_ctl;
    if (bus_wr && bus_addr == 2'd0) nc = bus_wdata[7:4];
    if (arb_lost && m_ctl[1]) nc[1:0] = 2'b00;
    else if (addr_byte_done && m_ctl[1:0] == 2'b00 && !m_sar[0]) nc[1:0] = {1'b0, addr_rw};
    if (bus_wr && bus_addr == 2'd1) begin
      if (m_ctl[3]) m_mode = bus_wdata;
      else m_sar = bus_wdata;
    end
    if (evt_set) m_pend = 1'b1;
    else if (bus_wr && bus_addr == 2'd2 && !bus_wdata[0]) m_pend = 1'b0;
    m_ctl = nc;
  endtask

  task automatic step(input logic [1:0] a, input logic wr, input logic [7:0] wd,
                      input logic al, input logic bd, input logic rw, input logic es,
                      input logic sclr, input logic sdar, input logic wp);
    bus_addr = a; bus_wr = wr; bus_wdata = wd;
    arb_lost = al; addr_byte_done = bd; addr_rw = rw; evt_set = es;
    scl_drive_req = sclr; sda_drive_req = sdar; wait_pri = wp;
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(a, 1'b1, d, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] a);
    step(a, 1'b0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    arb_lost = 0; addr_byte_done = 0; addr_rw = 0; evt_set = 0;
    scl_drive_req = 0; sda_drive_req = 0; wait_pri = 0;
    m_ctl = 0; m_sar = 0; m_mode = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R1";
    for (int a = 0; a < 4; a++) rd(a[1:0]);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);

    cur_req = "R3";
    wr(1, 8'hA4); rd(1);
    wr(0, 8'h80); rd(1);
    wr(1, 8'h3C); rd(1);
    wr(0, 8'h00); rd(1);
    wr(0, 8'h80); rd(1);

    cur_req = "R2";
    wr(0, 8'h00);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    wr(0, 8'h80);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

    cur_req = "R9";
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);

    cur_req = "R5";
    for (int m = 0; m < 4; m++) begin
      wr(0, 8'h80 | 8'(m << 4));
      rd(0);
    end

    cur_req = "R6";
    wr(0, 8'hB0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h90);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd(0);

    cur_req = "R7";
    wr(0, 8'h80);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h80);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    wr(0, 8'hA0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h00); wr(1, 8'hA5); wr(0, 8'h80);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h00); wr(1, 8'hA4); wr(0, 8'h80);

    cur_req = "R8";
    wr(0, 8'hB0);
    step(0, 1, 8'h70, 1, 0, 0, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h80);
    step(0, 1, 8'hF0, 0, 1, 0, 0, 0, 0, 0);
    rd(0);
    wr(0, 8'h80);
    step(0, 1, 8'hE0, 0, 1, 1, 0, 0, 0, 0);
    rd(0);

    cur_req = "R4";
    wr(0, 8'h80);
    step(2, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    rd(2);
    wr(0, 8'hC0); rd(2);

    cur_req = "R10";
    wr(2, 8'h01); rd(2);
    wr(2, 8'hFE); rd(2);
    step(2, 1, 8'h00, 0, 0, 0, 1, 0, 0, 0);
    rd(2);

    cur_req = "R11";
    wr(0, 8'hF0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    rd(0); rd(3); rd(2);

    cur_req = "random";
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      step(a, ($urandom_range(0, 3) == 0), d,
           ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) == 0),
           1'($urandom), ($urandom_range(0, 6) == 0),
           1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule